// File: doc/BRIEF.md
# Quadrature Position Step Counter

This block turns the two phase signals of an incremental encoder into a signed motion count. Both phases and a clear request arrive asynchronously, and all three pass through a synchroniser first. The block compares each synchronised {A,B} pair with the previous one. A single-bit change in the forward order moves the count up one step. A single-bit change in the reverse order moves it down one step. Every edge of either phase therefore counts, which gives four steps per full input cycle. A change of both bits in one sample cannot be resolved. It is dropped and reported on an error output.

The count is CNT_W bits wide (8 by default) and is visible at all times. It wraps at both ends. A wrap upward drives a fixed-width active-low carry pulse, and a wrap downward drives a fixed-width active-low borrow pulse. A second counter stage can be chained from these pulses. While the clear request is held, the count stays at zero. A downward step taken during that time still produces a borrow pulse, so a chained upper stage that is cleared at the same time stays in step. A one-cycle strobe and a direction flag report each accepted step to downstream logic.

Top module: `quad_step_counter`

## Requirements
- R1: With the {enc_a,enc_b} pair stepping 00→10→11→01→00 (A leading B), each transition adds one to count_o.
- R2: With the pair stepping 00→01→11→10→00 (B leading A), each transition subtracts one from count_o.
- R3: A single-bit phase change is reflected on count_o, step_o (high for one cycle) and dir_up_o (1 for up, 0 for down, held until the next step) on the third rising clock edge after the input changes. count_o does not change without a step or a clear.
- R4: An up step from all-ones sets count_o to zero and drives carry_n_o low.
- R5: A down step from zero sets count_o to all-ones and drives borrow_n_o low.
- R6: carry_n_o and borrow_n_o stay low for exactly PULSE_W cycles (2 by default) after a wrap, whatever the input rate, and are high at all other times.
- R7: While the synchronised clr_in is high, count_o is zero.
- R8: During a clear, a down step drives borrow_n_o low for PULSE_W cycles, and an up step produces no carry pulse. Either step still pulses step_o.
- R9: An up step followed by a down step (a glitch on one phase) returns count_o to its value before the glitch.
- R10: A change of both phase bits in one sample leaves count_o unchanged, gives no step_o, and raises seq_err_o for one cycle.
- R11: After the synchronous reset rst, count_o is zero, carry_n_o and borrow_n_o are high, and step_o, dir_up_o and seq_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Phase A, asynchronous |
| enc_b | input | 1 | Phase B, asynchronous |
| clr_in | input | 1 | Asynchronous active-high count clear, level held |
| count_o | output | CNT_W | Current count |
| step_o | output | 1 | One-cycle strobe per accepted step |
| dir_up_o | output | 1 | Direction of the last step, 1 = up |
| seq_err_o | output | 1 | One-cycle flag for a double phase change |
| carry_n_o | output | 1 | Active-low wrap-up pulse |
| borrow_n_o | output | 1 | Active-low wrap-down pulse |

## Verification
Every phase or clear change reaches the outputs on the third rising edge after it is applied. That takes two synchroniser stages and one counting register. A wrap pulse then stays low through PULSE_W sampling points and is high again at the next one. The driver applies each stimulus at a falling edge. It queues the expected count, strobe, direction, error and pulse levels, each tagged with its due cycle: the drive cycle plus three, then one item for each following cycle up to PULSE_W later. The monitor compares at the falling edge of exactly that cycle. The driver spaces its events so that the windows of two events never overlap.

// File: rtl/qsc_pkg.sv
package qsc_pkg;
  // Classification of one sampled phase transition
  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2,
    MOVE_BAD  = 2'd3
  } move_e;
endpackage

// File: rtl/qsc_sync.sv
module qsc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/qsc_phase_decode.sv
module qsc_phase_decode
  import qsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  a_i,
  input  logic  b_i,
  output move_e move_o
);
  logic [1:0] prev_q;
  logic [1:0] cur;

  assign cur = {a_i, b_i};

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 2'b00;
    else     prev_q <= cur;
  end

  // Forward Gray order: 00 -> 10 -> 11 -> 01 -> 00
  always_comb begin
    unique case ({prev_q, cur})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: move_o = MOVE_UP;
      4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: move_o = MOVE_DOWN;
      4'b00_11, 4'b11_00, 4'b01_10, 4'b10_01: move_o = MOVE_BAD;
      default:                                move_o = MOVE_NONE;
    endcase
  end
endmodule

// File: rtl/qsc_wrap_pulse.sv
module qsc_wrap_pulse #(
  parameter int WIDTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_n_o
);
  localparam int CW = $clog2(WIDTH + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      pulse_n_o <= 1'b1;
    end else if (fire_i) begin
      left_q    <= CW'(WIDTH - 1);
      pulse_n_o <= 1'b0;
    end else if (left_q != '0) begin
      left_q    <= left_q - 1'b1;
      pulse_n_o <= 1'b0;
    end else begin
      pulse_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/quad_step_counter.sv
module quad_step_counter
  import qsc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PULSE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             clr_in,
  output logic [CNT_W-1:0] count_o,
  output logic             step_o,
  output logic             dir_up_o,
  output logic             seq_err_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam int          SYNC_W = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn;
  logic              a_s, b_s, clr_s;
  move_e             mv;
  logic              up_ev, dn_ev;
  logic              carry_fire, borrow_fire;
  logic [CNT_W-1:0]  count_q;

  assign raw_in = {clr_in, enc_a, enc_b};

  qsc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn)
  );

  assign clr_s = syn[2];
  assign a_s   = syn[1];
  assign b_s   = syn[0];

  qsc_phase_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .a_i    (a_s),
    .b_i    (b_s),
    .move_o (mv)
  );

  always_comb begin
    up_ev       = (mv == MOVE_UP);
    dn_ev       = (mv == MOVE_DOWN);
    carry_fire  = up_ev && !clr_s && (count_q == CNT_MAX);
    borrow_fire = dn_ev && (clr_s || (count_q == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      step_o    <= 1'b0;
      dir_up_o  <= 1'b0;
      seq_err_o <= 1'b0;
    end else begin
      step_o    <= up_ev || dn_ev;
      seq_err_o <= (mv == MOVE_BAD);
      if (up_ev || dn_ev) dir_up_o <= up_ev;
      if (clr_s)      count_q <= '0;
      else if (up_ev) count_q <= count_q + 1'b1;
      else if (dn_ev) count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;

  qsc_wrap_pulse #(.WIDTH(PULSE_W)) u_carry (
    .clk       (clk),
    .rst       (rst),
    .fire_i    (carry_fire),
    .pulse_n_o (carry_n_o)
  );

  qsc_wrap_pulse #(.WIDTH(PULSE_W)) u_borrow (
    .clk       (clk),
    .rst       (rst),
    .fire_i    (borrow_fire),
    .pulse_n_o (borrow_n_o)
  );
endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
  parameter int CNT_W   = 8,
  parameter int PULSE_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_s,
  input logic [CNT_W-1:0] count_o,
  input logic             step_o,
  input logic             dir_up_o,
  input logic             seq_err_o,
  input logic             carry_n_o,
  input logic             borrow_n_o
);
  logic [15:0] car_low, brw_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      car_low <= '0;
      brw_low <= '0;
    end else begin
      car_low <= (carry_n_o  || step_o) ? 16'd0 : car_low + 16'd1;
      brw_low <= (borrow_n_o || step_o) ? 16'd0 : brw_low + 16'd1;
    end
  end

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_o && dir_up_o && !$past(clr_s)) |-> count_o == CNT_W'($past(count_o) + 1'b1)); // R1
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_o && !dir_up_o && !$past(clr_s)) |-> count_o == CNT_W'($past(count_o) - 1'b1)); // R2
  AST_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    (!step_o && !$past(clr_s)) |-> $stable(count_o)); // R3
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst)
    $fell(carry_n_o) |-> (count_o == '0 && $past(count_o) == '1)); // R4
  AST_BORROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    $fell(borrow_n_o) |-> ((count_o == '1 && $past(count_o) == '0) || $past(clr_s))); // R5
  AST_CARRY_WIDTH: assert property (@(posedge clk) disable iff (rst)
    !carry_n_o |-> car_low < PULSE_W); // R6
  AST_BORROW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    !borrow_n_o |-> brw_low < PULSE_W); // R6
  AST_CLEAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    clr_s |=> count_o == '0); // R7
  AST_NO_CARRY_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(carry_n_o) |-> !$past(clr_s)); // R8
  AST_BAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (seq_err_o && !$past(clr_s)) |-> (!step_o && $stable(count_o))); // R10
endmodule

bind quad_step_counter qsc_checker #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_qsc_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_s      (clr_s),
  .count_o    (count_o),
  .step_o     (step_o),
  .dir_up_o   (dir_up_o),
  .seq_err_o  (seq_err_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o)
);

// File: tb/quad_step_counter_bench.sv
module quad_step_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W   = 8;
  localparam int PULSE_W = 2;
  localparam int LAT     = 3;

  logic clk = 1'b0, rst = 1'b1, enc_a = 1'b0, enc_b = 1'b0, clr_in = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic step_o, dir_up_o, seq_err_o, carry_n_o, borrow_n_o;

  quad_step_counter #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .SYNC_STAGES(2)) u_quad_step_counter (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .clr_in(clr_in),
    .count_o(count_o), .step_o(step_o), .dir_up_o(dir_up_o), .seq_err_o(seq_err_o),
    .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    int               due;
    logic [CNT_W-1:0] cnt;
    logic             carry_n, borrow_n, step, dir, err;
    logic [31:0]      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit summary_done = 0;

  logic [1:0]       m_ab  = 2'b00;
  logic [CNT_W-1:0] m_cnt = '0;
  logic             m_dir = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] fwd_next(input logic [1:0] s);
    case (s)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: apply one input state and queue the expected results
  task automatic ev(input logic a, input logic b, input logic c, input logic [31:0] tag);
    logic [1:0] na, chg;
    logic up, dn, bad, fc, fb;
    exp_t e;
    @(negedge clk);
    na  = {a, b};
    chg = na ^ m_ab;
    up  = ($countones(chg) == 1) && (na == fwd_next(m_ab));
    dn  = ($countones(chg) == 1) && !up;
    bad = (chg == 2'b11);
    fc  = up && !c && (m_cnt == '1);
    fb  = dn && (c || m_cnt == '0);
    if (c)       m_cnt = '0;
    else if (up) m_cnt = m_cnt + 1'b1;
    else if (dn) m_cnt = m_cnt - 1'b1;
    if (up || dn) m_dir = up;
    m_ab = na;
    enc_a = a; enc_b = b; clr_in = c;
    for (int k = 0; k <= PULSE_W; k++) begin
      e.due      = cyc + LAT + k;
      e.cnt      = m_cnt;
      e.carry_n  = !(fc && k < PULSE_W);
      e.borrow_n = !(fb && k < PULSE_W);
      e.step     = (k == 0) && (up || dn);
      e.dir      = m_dir;
      e.err      = (k == 0) && bad;
      e.tag      = tag;
      q.push_back(e);
    end
    repeat (PULSE_W) @(negedge clk);
  endtask

  // Monitor: compare when each queued item falls due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic [CNT_W+4:0] act, expv;
      e = q.pop_front();
      act  = {count_o, carry_n_o, borrow_n_o, step_o, dir_up_o, seq_err_o};
      expv = {e.cnt, e.carry_n, e.borrow_n, e.step, e.dir, e.err};
      checks++;
      if (act !== expv) begin
        errors++;
        $display("FAIL %s cyc %0d: {cnt,car_n,brw_n,step,dir,err} actual %h expected %h",
                 e.tag, cyc, act, expv);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++; // R11 reset state
    if ({count_o, carry_n_o, borrow_n_o, step_o, dir_up_o, seq_err_o} !== {8'h00, 5'b11000}) begin
      errors++;
      $display("FAIL R11: actual %h expected %h",
               {count_o, carry_n_o, borrow_n_o, step_o, dir_up_o, seq_err_o}, {8'h00, 5'b11000});
    end
    // R1 / R3: forward cycle, four steps
    ev(1,0,0,"R1  "); ev(1,1,0,"R3  "); ev(0,1,0,"R1  "); ev(0,0,0,"R3  ");
    // R2: reverse cycle back to zero
    ev(0,1,0,"R2  "); ev(1,1,0,"R2  "); ev(1,0,0,"R2  "); ev(0,0,0,"R2  ");
    // R5 / R6: down from zero wraps with a borrow
    ev(0,1,0,"R5  ");
    // R4 / R6: up from all-ones wraps with a carry
    ev(0,0,0,"R4  ");
    // R9: glitch on A, up then down
    ev(1,0,0,"R9  "); ev(0,0,0,"R9  ");
    // R10: double changes are ignored
    ev(1,1,0,"R10 "); ev(0,0,0,"R10 ");
    // R7 / R8: clear holds zero, steps during clear
    ev(1,0,0,"R1  "); ev(1,1,0,"R1  ");
    ev(1,1,1,"R7  ");
    ev(0,1,1,"R8  "); ev(1,1,1,"R8  ");
    ev(0,1,1,"R8  "); ev(0,0,1,"R8  ");
    ev(0,1,1,"R8  ");
    ev(0,1,0,"R7  ");
    ev(0,0,0,"R1  ");
    while (q.size() > 0) @(negedge clk);
    summary();
  end
endmodule